// File: doc/BRIEF.md
# Victim Buffer for a Direct-Mapped Cache

This block is a four-entry, fully associative store that sits beside a direct-mapped data cache. It keeps lines that the cache has just thrown out, so that a later conflict miss on one of them is served from the buffer rather than from the next memory level. Each entry holds a valid bit, a full line address as its tag, and one whole cache line. Because evicted lines can come from any cache index, the tag is the complete line address and not just the part above the index.

The cache controller uses two ports. On a cache miss it presents the missing line address on the lookup port. All entries are compared at once, and hit and line data come back combinationally in the same cycle. In the same cycle it may present, on the insert port, the line it is displacing. When the lookup hits, the hit line leaves the buffer and the displaced line takes its slot, so the two structures exchange lines and no line is held in both. A miss in both the cache and the buffer is left to the next level. New lines fill free slots first. When every slot is occupied, the slot written longest ago is replaced.

Top module: `victim_buf`

## Requirements
- R1: The asynchronous active-low reset invalidates every entry. After a reset, including one applied while lines are held, every lookup misses.
- R2: With `lk_valid` high, `lk_hit` and `lk_data` are valid combinationally in the same cycle. All entries are compared in parallel and a hit in any slot returns that slot's line.
- R3: With `lk_valid` low, `lk_hit` is 0 and no entry is removed, even if `lk_addr` matches a held line.
- R4: A line presented with `ins_valid` high, with no lookup of the same address, is stored on that clock edge. From the next cycle a lookup of its address hits and returns its data.
- R5: While any slot is invalid, an insert uses an invalid slot and no held line is lost.
- R6: When all slots are valid, an insert of a new address replaces the slot written longest ago. A swap counts as a write to its slot.
- R7: A lookup that hits a held line while a different new line is inserted swaps them: the hit address misses from the next cycle, the inserted line hits, and the number of held lines is unchanged.
- R8: A lookup that hits a held line with no insert removes that line, so it misses from the next cycle.
- R9: When insert and lookup carry the same address in the same cycle, the lookup hits with the insert data, and that line is not retained afterwards.
- R10: Inserting an address that is already held overwrites that entry's data in place and never creates a second entry.
- R11: Tags are full line addresses. Lines 0x0004 and 0x000C, which share index 4 of an 8-line cache (address modulo 8), are held at the same time and each returns its own data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| lk_valid | input | 1 | Lookup request for `lk_addr` |
| lk_addr | input | ADDR_W | Line address to search |
| lk_hit | output | 1 | Lookup found the line (same cycle) |
| lk_data | output | LINE_W | Line data on a hit, zero otherwise |
| ins_valid | input | 1 | Insert the displaced line this cycle |
| ins_addr | input | ADDR_W | Line address of the inserted line |
| ins_data | input | LINE_W | Data of the inserted line |

## Verification
Lookup results are combinational, so each check drives its inputs just after the falling edge and samples `lk_hit` and `lk_data` one nanosecond later, before the rising edge that commits any state change. The effects of an insert, swap, removal or reset are due from the cycle after the rising edge that registers them. The bench therefore checks them with a lookup in a later cycle and never in the cycle of the stimulus. Replacement order, swap and bypass are checked through sequences of misses and hits that only the required slot choice produces.

// File: rtl/vb_pkg.sv
package vb_pkg;
  localparam int VB_ENTRIES = 4;
  localparam int VB_ADDR_W  = 16;
  localparam int VB_LINE_W  = 64;

  // where the inserted line is written
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_ALLOC = 2'd1,
    SRC_HIT   = 2'd2,
    SRC_DUP   = 2'd3
  } wr_src_e;
endpackage

// File: rtl/vb_enc.sv
// Lowest-set-bit encoder (exact for one-hot inputs)
module vb_enc #(
  parameter int N = 4,
  parameter int W = 2
) (
  input  logic [N-1:0] vec,
  output logic [W-1:0] idx,
  output logic         any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = W'(i);
    end
    any = |vec;
  end
endmodule

// File: rtl/vb_entry.sv
module vb_entry #(
  parameter int ADDR_W = 16,
  parameter int LINE_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              clr_en,
  input  logic [ADDR_W-1:0] wr_tag,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [ADDR_W-1:0] lk_tag,
  input  logic [ADDR_W-1:0] ins_tag,
  output logic              valid_o,
  output logic [LINE_W-1:0] line_o,
  output logic              lk_match_o,
  output logic              ins_match_o
);
  logic              valid_q, valid_d;
  logic [ADDR_W-1:0] tag_q;
  logic [LINE_W-1:0] line_q;

  always_comb begin
    valid_d = valid_q;
    if (wr_en)       valid_d = 1'b1;
    else if (clr_en) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q  <= wr_tag;
      line_q <= wr_line;
    end
  end

  assign valid_o     = valid_q;
  assign line_o      = line_q;
  assign lk_match_o  = valid_q && (tag_q == lk_tag);
  assign ins_match_o = valid_q && (tag_q == ins_tag);

  // R8: a cleared slot is empty next cycle
  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !wr_en) |=> !valid_o);
  // R4: a written slot holds the written tag next cycle
  assert_write_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (valid_o && tag_q == $past(wr_tag)));
endmodule

// File: rtl/vb_age.sv
// Write-order tracker: rank 0 is newest, ENTRIES-1 oldest
module vb_age #(
  parameter int ENTRIES = 4,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] oldest_idx
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] age_q [ENTRIES];
  logic [IDX_W-1:0] age_d [ENTRIES];

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      age_d[i] = age_q[i];
      if (wr_en) begin
        if (IDX_W'(i) == wr_idx)         age_d[i] = '0;
        else if (age_q[i] < age_q[wr_idx]) age_d[i] = age_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
    end else begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= age_d[i];
    end
  end

  always_comb begin
    oldest_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (age_q[i] == OLDEST) oldest_idx = IDX_W'(i);
    end
  end

  // R6: the slot just written becomes the newest
  assert_written_newest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (age_q[$past(wr_idx)] == '0));
endmodule

// File: rtl/victim_buf.sv
module victim_buf
  import vb_pkg::*;
#(
  parameter int ENTRIES = VB_ENTRIES,
  parameter int ADDR_W  = VB_ADDR_W,
  parameter int LINE_W  = VB_LINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [LINE_W-1:0] lk_data,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [LINE_W-1:0] ins_data
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] valid_v, lk_m, ins_m, wr_v, clr_v;
  logic [LINE_W-1:0]  line_a [ENTRIES];

  logic [IDX_W-1:0] hit_idx, dup_idx, free_idx, oldest_idx, alloc_idx, wr_idx;
  logic             lk_any, ins_any, free_any;
  logic             stored_hit, bypass, ins_store, wr_en, clr_en;
  wr_src_e          src;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    vb_entry #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_ent (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_v[g]),
      .clr_en     (clr_v[g]),
      .wr_tag     (ins_addr),
      .wr_line    (ins_data),
      .lk_tag     (lk_addr),
      .ins_tag    (ins_addr),
      .valid_o    (valid_v[g]),
      .line_o     (line_a[g]),
      .lk_match_o (lk_m[g]),
      .ins_match_o(ins_m[g])
    );
    assign wr_v[g]  = wr_en  && (wr_idx  == IDX_W'(g));
    assign clr_v[g] = clr_en && (hit_idx == IDX_W'(g));
  end

  vb_enc #(.N(ENTRIES), .W(IDX_W)) u_hit_enc  (.vec(lk_m),     .idx(hit_idx),  .any(lk_any));
  vb_enc #(.N(ENTRIES), .W(IDX_W)) u_dup_enc  (.vec(ins_m),    .idx(dup_idx),  .any(ins_any));
  vb_enc #(.N(ENTRIES), .W(IDX_W)) u_free_enc (.vec(~valid_v), .idx(free_idx), .any(free_any));

  vb_age #(.ENTRIES(ENTRIES)) u_age (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .oldest_idx(oldest_idx)
  );

  always_comb begin
    stored_hit = lk_valid && lk_any;
    bypass     = lk_valid && ins_valid && (ins_addr == lk_addr);
    ins_store  = ins_valid && !bypass;
    alloc_idx  = free_any ? free_idx : oldest_idx;

    if (!ins_store)     src = SRC_NONE;
    else if (ins_any)   src = SRC_DUP;
    else if (stored_hit) src = SRC_HIT;
    else                src = SRC_ALLOC;

    unique case (src)
      SRC_DUP:   wr_idx = dup_idx;
      SRC_HIT:   wr_idx = hit_idx;
      SRC_ALLOC: wr_idx = alloc_idx;
      default:   wr_idx = '0;
    endcase
    wr_en  = (src != SRC_NONE);
    clr_en = stored_hit && !(wr_en && wr_idx == hit_idx);

    lk_hit  = bypass || stored_hit;
    lk_data = '0;
    if (bypass)          lk_data = ins_data;
    else if (stored_hit) lk_data = line_a[hit_idx];
  end

  // R10: an address is never held twice
  assert_single_copy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_m));
  // R8: a hit with nothing inserted removes exactly one line
  assert_hit_removes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stored_hit && !ins_store) |=> ($countones(valid_v) + 1 == $past($countones(valid_v))));
  // R7: a swap keeps the number of held lines
  assert_swap_keeps_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stored_hit && ins_store && !ins_any) |=> $stable($countones(valid_v)));
  // R5: a new line into a non-full buffer adds one line
  assert_fill_grows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_store && !stored_hit && !ins_any && !(&valid_v))
      |=> ($countones(valid_v) == $past($countones(valid_v)) + 1));
  // R9: a bypassed line is not retained
  assert_bypass_no_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && !lk_any) |=> $stable($countones(valid_v)));
  // R3: no removal without a lookup
  assert_idle_no_loss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!lk_valid && !ins_valid) |=> $stable(valid_v));
endmodule

// File: tb/victim_buf_tb.sv
`timescale 1ns/1ps
module victim_buf_tb;
  localparam int AW = 16;
  localparam int LW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_valid = 1'b0;
  logic [AW-1:0] lk_addr = '0;
  logic          lk_hit;
  logic [LW-1:0] lk_data;
  logic          ins_valid = 1'b0;
  logic [AW-1:0] ins_addr = '0;
  logic [LW-1:0] ins_data = '0;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  victim_buf u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data),
    .ins_valid(ins_valid), .ins_addr(ins_addr), .ins_data(ins_data)
  );

  function automatic logic [LW-1:0] mk(input logic [15:0] s);
    return {s, ~s, s ^ 16'hA5A5, s + 16'h1};
  endfunction

  typedef struct packed {
    logic       lv;
    logic [15:0] la;
    logic       iv;
    logic [15:0] ia;
    logic [15:0] is;
    logic       eh;
    logic [15:0] es;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 16'h0004, 1'b0, 16'h0000, 16'h0000, 1'b0, 16'h0000, 4'd1},  // R1 empty after reset
    '{1'b0, 16'h0004, 1'b1, 16'h0004, 16'h00A1, 1'b0, 16'h0000, 4'd3},  // R3 no lookup, no hit
    '{1'b0, 16'h0000, 1'b1, 16'h000C, 16'h00A2, 1'b0, 16'h0000, 4'd3},
    '{1'b0, 16'h0000, 1'b1, 16'h0010, 16'h00A3, 1'b0, 16'h0000, 4'd3},
    '{1'b0, 16'h0000, 1'b1, 16'h0021, 16'h00A4, 1'b0, 16'h0000, 4'd3},
    '{1'b1, 16'h000C, 1'b0, 16'h0000, 16'h0000, 1'b1, 16'h00A2, 4'd11}, // R11 same index, own data
    '{1'b1, 16'h000C, 1'b0, 16'h0000, 16'h0000, 1'b0, 16'h0000, 4'd8},  // R8 removed by hit
    '{1'b0, 16'h0000, 1'b1, 16'h0033, 16'h00A5, 1'b0, 16'h0000, 4'd5},  // R5 refill free slot
    '{1'b1, 16'h0004, 1'b1, 16'h0044, 16'h00A6, 1'b1, 16'h00A1, 4'd4},  // R4 R7 hit and swap
    '{1'b1, 16'h0004, 1'b0, 16'h0000, 16'h0000, 1'b0, 16'h0000, 4'd7},  // R7 swapped out
    '{1'b1, 16'h0044, 1'b1, 16'h0004, 16'h00A1, 1'b1, 16'h00A6, 4'd7},  // R7 swapped-in line
    '{1'b0, 16'h0000, 1'b1, 16'h0055, 16'h00A7, 1'b0, 16'h0000, 4'd6},  // R6 full, evict oldest
    '{1'b1, 16'h0010, 1'b0, 16'h0000, 16'h0000, 1'b0, 16'h0000, 4'd6},  // R6 0x0010 was oldest
    '{1'b1, 16'h0021, 1'b0, 16'h0000, 16'h0000, 1'b1, 16'h00A4, 4'd5},  // R5 survivor kept
    '{1'b1, 16'h0066, 1'b1, 16'h0066, 16'h00A8, 1'b1, 16'h00A8, 4'd9},  // R9 bypass
    '{1'b1, 16'h0066, 1'b0, 16'h0000, 16'h0000, 1'b0, 16'h0000, 4'd9},  // R9 not retained
    '{1'b0, 16'h0000, 1'b1, 16'h0033, 16'h00A9, 1'b0, 16'h0000, 4'd10}, // R10 overwrite
    '{1'b1, 16'h0033, 1'b0, 16'h0000, 16'h0000, 1'b1, 16'h00A9, 4'd10}, // R10 new data
    '{1'b1, 16'h0033, 1'b0, 16'h0000, 16'h0000, 1'b0, 16'h0000, 4'd10}  // R10 no second copy
  };

  task automatic check(input string req, input logic eh, input logic [LW-1:0] ed);
    n_checks++;
    if (lk_hit !== eh) begin
      n_fails++;
      $display("FAIL %s: lk_hit=%0b expected %0b (addr %h)", req, lk_hit, eh, lk_addr);
    end else if (eh && lk_data !== ed) begin
      n_fails++;
      $display("FAIL %s: lk_data=%h expected %h (addr %h)", req, lk_data, ed, lk_addr);
    end
  endtask

  task automatic step(input logic lv, input logic [AW-1:0] la, input logic iv,
                      input logic [AW-1:0] ia, input logic [15:0] is,
                      input logic eh, input logic [15:0] es, input string req);
    @(negedge clk);
    lk_valid = lv; lk_addr = la; ins_valid = iv; ins_addr = ia; ins_data = mk(is);
    #1;
    check(req, eh, mk(es));
  endtask

  task automatic put(input logic [AW-1:0] a, input logic [15:0] s);
    step(1'b0, '0, 1'b1, a, s, 1'b0, 16'h0, "R4");
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      step(TBL[k].lv, TBL[k].la, TBL[k].iv, TBL[k].ia, TBL[k].is,
           TBL[k].eh, TBL[k].es, $sformatf("R%0d", TBL[k].req));
    end

    // R1: reset while lines 0x0004 and 0x0055 are held
    @(negedge clk);
    lk_valid = 1'b0; ins_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = 16'h0004;
    #1 check("R1", 1'b0, '0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 16'h0055, 1'b0, '0, 16'h0, 1'b0, 16'h0, "R1");

    // R6 and R2: six fills, the first two written are evicted
    for (int k = 0; k < 6; k++) put(AW'(16'h0100 + k), 16'h0B00 + 16'(k));
    step(1'b1, 16'h0100, 1'b0, '0, 16'h0, 1'b0, 16'h0, "R6");
    step(1'b1, 16'h0101, 1'b0, '0, 16'h0, 1'b0, 16'h0, "R6");
    for (int k = 2; k < 6; k++)
      step(1'b1, AW'(16'h0100 + k), 1'b0, '0, 16'h0, 1'b1, 16'h0B00 + 16'(k), "R2");

    // R3: matching address without lk_valid neither hits nor removes
    put(16'h0200, 16'h0C00);
    step(1'b0, 16'h0200, 1'b0, '0, 16'h0, 1'b0, 16'h0, "R3");
    step(1'b1, 16'h0200, 1'b0, '0, 16'h0, 1'b1, 16'h0C00, "R3");

    @(negedge clk);
    lk_valid = 1'b0; ins_valid = 1'b0;
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    finish_run();
  end
endmodule